// File: doc/BRIEF.md
# Per-Lane Byte Gather and Transform Unit

This block builds a 128-bit result from two 128-bit source vectors under the control of a 128-bit control vector. Each of the sixteen result bytes is produced independently: its own control byte chooses one byte out of a 32-byte pool formed from the two sources, then applies one of eight byte transforms to it. The transforms are pass-through, complement, bit-order reversal, complemented reversal, forcing all zeros or all ones, and spreading the sign bit (plain or complemented) across the byte.

A caller presents the sources and control together with a valid strobe. The transformed vector and its valid flag appear from a register one clock later. With a suitable control vector the unit reverses byte order inside each 64-bit half, which flips an 8x8 bitboard vertically. It can also mirror every byte's bits, which flips a bitboard horizontally, or do both at once, which rotates a bitboard by 180 degrees. The same unit also serves as a general byte shuffle, a 32-entry byte lookup and a sign or zero extender.

Top module: `bytesel_xform_unit`

## Requirements
- R1: Result lane i, at bits [8i+7:8i], depends only on control byte i, at bits [8i+7:8i], and on the two sources. Lanes do not affect each other.
- R2: Control bits [4:0] select a pool byte. Values 0 to 15 pick byte n of `src_lo`, at bits [8n+7:8n]. Values 16 to 31 pick byte n-16 of `src_hi`.
- R3: Control bits [7:5] hold the transform code. Code 0 outputs the picked byte unchanged, and code 1 outputs its bitwise complement.
- R4: Code 2 outputs the picked byte with its bit order reversed, so bit k moves to bit 7-k. Code 3 outputs the complement of that reversed byte.
- R5: Code 4 outputs 0x00 and code 5 outputs 0xFF, whatever the picked byte holds.
- R6: Code 6 outputs 0xFF when bit 7 of the picked byte is 1 and 0x00 otherwise. Code 7 outputs 0xFF when that bit is 0 and 0x00 otherwise.
- R7: Inputs are sampled on a rising edge where `in_valid` is 1. On that same edge `result` takes the transformed vector and `out_valid` goes to 1. On an edge where `in_valid` is 0, `out_valid` goes to 0.
- R8: A synchronous active-high `rst` sets `out_valid` to 0 and `result` to 0 on the next rising edge.
- R9: While `in_valid` is 0, `result` keeps its value, even when the source and control inputs change.
- R10: Three control patterns, all with code 0 or code 2, act on each 64-bit half. Code 0 with indices 7..0 in lanes 0..7 and 15..8 in lanes 8..15 reverses the byte order. Code 2 with index i in lane i mirrors each byte's bits. Code 2 with the byte-reversing indices reverses all 64 bits of each half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies src_lo, src_hi and ctrl on this edge |
| src_lo | input | 128 | Pool bytes 0 to 15 |
| src_hi | input | 128 | Pool bytes 16 to 31 |
| ctrl | input | 128 | One control byte per lane: transform code in [7:5], pool index in [4:0] |
| out_valid | output | 1 | Result register holds a fresh vector |
| result | output | 128 | Registered transformed vector |

## Verification
Each result is due exactly one rising edge after the edge that samples the inputs with `in_valid` high. The bench changes inputs on falling edges, waits for the next rising edge, and reads `result` and `out_valid` one nanosecond later, so every comparison sees the register as that single edge left it. Hold and reset checks use the same timing. The bench first changes the inputs with `in_valid` low or `rst` high, then reads the ports after the following rising edge, before any new sample is taken.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 16;
    localparam int VEC_W  = LANES * BYTE_W;
    localparam int POOL   = 2 * LANES;
    localparam int IDX_W  = $clog2(POOL);
    localparam int OP_W   = BYTE_W - IDX_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [OP_W-1:0] {
        XF_PASS   = 3'd0,
        XF_INV    = 3'd1,
        XF_REV    = 3'd2,
        XF_REVINV = 3'd3,
        XF_ZERO   = 3'd4,
        XF_ONES   = 3'd5,
        XF_SIGN   = 3'd6,
        XF_NSIGN  = 3'd7
    } xform_e;

    typedef struct packed {
        xform_e             code;
        logic [IDX_W-1:0]   idx;
    } lane_ctrl_t;

    function automatic byte_t bit_mirror(byte_t b);
        byte_t r;
        for (int k = 0; k < BYTE_W; k++) r[k] = b[BYTE_W-1-k];
        return r;
    endfunction

    function automatic byte_t fill_bit(logic s);
        return {BYTE_W{s}};
    endfunction
endpackage

// File: rtl/bsx_pool_mux.sv
module bsx_pool_mux
    import bsx_pkg::*;
(
    input  logic [VEC_W-1:0] lo,
    input  logic [VEC_W-1:0] hi,
    input  logic [IDX_W-1:0] idx,
    output byte_t            picked
);
    logic [2*VEC_W-1:0] pool;

    always_comb begin
        pool   = {hi, lo};
        picked = pool[int'(idx)*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/bsx_lane_op.sv
module bsx_lane_op
    import bsx_pkg::*;
(
    input  xform_e code,
    input  byte_t  picked,
    output byte_t  out
);
    byte_t mirrored;

    always_comb begin
        mirrored = bit_mirror(picked);
        unique case (code)
            XF_PASS:   out = picked;
            XF_INV:    out = ~picked;
            XF_REV:    out = mirrored;
            XF_REVINV: out = ~mirrored;
            XF_ZERO:   out = '0;
            XF_ONES:   out = '1;
            XF_SIGN:   out = fill_bit(picked[BYTE_W-1]);
            XF_NSIGN:  out = fill_bit(~picked[BYTE_W-1]);
            default:   out = '0;
        endcase
    end

    always_comb begin
        // R3
        inv_pair_chk: assert (code != XF_INV || (out ^ picked) == '1);
        // R4
        rev_weight_chk: assert (code != XF_REV ||
                                $countones(out) == $countones(picked));
        // R5
        const_lane_chk: assert (!(code inside {XF_ZERO, XF_ONES}) ||
                                out == fill_bit(code == XF_ONES));
        // R6
        sign_spread_chk: assert (!(code inside {XF_SIGN, XF_NSIGN}) ||
                                 ($countones(out) % BYTE_W == 0 &&
                                  out[0] == (picked[BYTE_W-1] ^ (code == XF_NSIGN))));
    end
endmodule

// File: rtl/bsx_lane_array.sv
module bsx_lane_array
    import bsx_pkg::*;
(
    input  logic [VEC_W-1:0] src_lo,
    input  logic [VEC_W-1:0] src_hi,
    input  logic [VEC_W-1:0] ctrl,
    output logic [VEC_W-1:0] xformed
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctrl_t c;
        byte_t      picked;
        byte_t      lane_out;

        assign c = lane_ctrl_t'(ctrl[g*BYTE_W +: BYTE_W]);

        bsx_pool_mux u_mux (
            .lo     (src_lo),
            .hi     (src_hi),
            .idx    (c.idx),
            .picked (picked)
        );

        bsx_lane_op u_op (
            .code   (c.code),
            .picked (picked),
            .out    (lane_out)
        );

        assign xformed[g*BYTE_W +: BYTE_W] = lane_out;
    end
endmodule

// File: rtl/bytesel_xform_unit.sv
module bytesel_xform_unit
    import bsx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_lo,
    input  logic [VEC_W-1:0] src_hi,
    input  logic [VEC_W-1:0] ctrl,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    logic [VEC_W-1:0] xformed;

    bsx_lane_array u_lanes (
        .src_lo  (src_lo),
        .src_hi  (src_hi),
        .ctrl    (ctrl),
        .xformed (xformed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= xformed;
        end
    end

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
endmodule

// File: tb/bytesel_xform_unit_test.sv
module bytesel_xform_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_lo = '0;
    logic [127:0] src_hi = '0;
    logic [127:0] ctrl = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bytesel_xform_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_lo    (src_lo),
        .src_hi    (src_hi),
        .ctrl      (ctrl),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [7:0] model_byte(logic [127:0] a, logic [127:0] b, logic [7:0] s);
        logic [255:0] pool;
        logic [7:0]   x, r;
        int           n;
        pool = {b, a};
        n = int'(s[4:0]);
        x = pool[n*8 +: 8];
        for (int k = 0; k < 8; k++) r[7-k] = x[k];
        case (s[7:5])
            3'd0: return x;
            3'd1: return ~x;
            3'd2: return r;
            3'd3: return ~r;
            3'd4: return 8'h00;
            3'd5: return 8'hFF;
            3'd6: return x[7] ? 8'hFF : 8'h00;
            default: return x[7] ? 8'h00 : 8'hFF;
        endcase
    endfunction

    function automatic string tag_for(logic [2:0] code);
        case (code)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_word(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-lane comparison; lanes carry different control bytes (R1)
    task automatic check_lanes(string req, logic [127:0] a, logic [127:0] b, logic [127:0] s);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e, g;
            string t;
            e = model_byte(a, b, s[i*8 +: 8]);
            g = result[i*8 +: 8];
            t = (req != "") ? req : tag_for(s[i*8+5 +: 3]);
            n_checks++;
            if (g !== e) begin
                n_fail++;
                $display("FAIL %s (R1 lane %0d ctrl %h): actual %h expected %h",
                         t, i, s[i*8 +: 8], g, e);
            end
        end
    endtask

    task automatic drive(logic [127:0] a, logic [127:0] b, logic [127:0] s);
        @(negedge clk);
        src_lo = a; src_hi = b; ctrl = s; in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [127:0] rand128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [127:0] pattern(logic [2:0] code, bit flip);
        logic [127:0] s;
        for (int i = 0; i < 16; i++) begin
            int base, j;
            base = (i / 8) * 8;
            j = flip ? base + 7 - (i - base) : i;
            s[i*8 +: 8] = {code, 5'(j)};
        end
        return s;
    endfunction

    function automatic logic [63:0] byte_swap64(logic [63:0] v);
        return {<<8{v}};
    endfunction

    function automatic logic [63:0] bit_swap64(logic [63:0] v);
        return {<<{v}};
    endfunction

    initial begin
        #800000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] a, b, s, held, m;
        void'($urandom(32'd4711));

        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check_bit("R8 out_valid after reset", out_valid, 1'b0);
        check_word("R8 result after reset", result, '0);
        @(negedge clk); rst = 1'b0;

        // R2 directed: identity from low source, then high source
        a = 128'h0F0E0D0C0B0A09080706050403020100;
        b = 128'h1F1E1D1C1B1A19181716151413121110 ^ {16{8'hA0}};
        s = pattern(3'd0, 1'b0);
        drive(a, b, s);
        check_word("R2 low pool", result, a);
        s = s | {16{8'h10}};
        drive(a, b, s);
        check_word("R2 high pool", result, b);
        // R7 valid high one cycle after a sampled input
        check_bit("R7 out_valid", out_valid, 1'b1);

        // full control-byte sweep: all 256 values, random sources
        for (int round = 0; round < 4; round++) begin
            for (int k = 0; k < 16; k++) begin
                a = rand128(); b = rand128();
                for (int i = 0; i < 16; i++) s[i*8 +: 8] = 8'(k*16 + i);
                drive(a, b, s);
                check_lanes("", a, b, s);
            end
        end

        // R5 constants with extreme sources
        s = {8{8'h9F, 8'hA3}};
        drive('0, '0, s);
        check_lanes("R5", '0, '0, s);
        drive('1, '1, s);
        check_lanes("R5", '1, '1, s);

        // R6 sign spread on sign-bit boundary sources
        s = {8{8'hC5, 8'hE5}};
        drive({16{8'h80}}, '0, s);
        check_lanes("R6", {16{8'h80}}, '0, s);
        drive({16{8'h7F}}, '0, s);
        check_lanes("R6", {16{8'h7F}}, '0, s);

        // random mixed stimulus
        for (int n = 0; n < 300; n++) begin
            a = rand128(); b = rand128(); s = rand128();
            drive(a, b, s);
            check_lanes("", a, b, s);
        end

        // R10 bitboard patterns
        a = rand128(); b = rand128();
        drive(a, b, pattern(3'd0, 1'b1));
        check_word("R10 vertical flip", result, {byte_swap64(a[127:64]), byte_swap64(a[63:0])});
        drive(a, b, pattern(3'd2, 1'b0));
        for (int i = 0; i < 16; i++) m[i*8 +: 8] = {<<{a[i*8 +: 8]}};
        check_word("R10 horizontal mirror", result, m);
        drive(a, b, pattern(3'd2, 1'b1));
        check_word("R10 rotate 180", result, {bit_swap64(a[127:64]), bit_swap64(a[63:0])});

        // R9 hold while in_valid low, R7 valid drops
        held = result;
        @(negedge clk);
        in_valid = 1'b0; src_lo = rand128(); src_hi = rand128(); ctrl = rand128();
        @(posedge clk); #1;
        check_bit("R7 out_valid drop", out_valid, 1'b0);
        check_word("R9 hold", result, held);
        @(negedge clk);
        ctrl = ~ctrl; src_lo = ~src_lo;
        @(posedge clk); #1;
        check_word("R9 hold second cycle", result, held);

        // R8 reset mid-run
        a = rand128(); b = rand128(); s = rand128();
        drive(a, b, s);
        check_lanes("", a, b, s);
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        check_bit("R8 out_valid mid-run reset", out_valid, 1'b0);
        check_word("R8 result mid-run reset", result, '0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule